// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core from the moment an exception is raised to the first fetch of its service routine. The core presents a request with an exception number, the program counter to be preserved, the current status word, the stack pointer and the base address of the handler table. The sequencer accepts the request, holds off further requests, and then makes three accesses on a single-port memory interface. First it reads the handler address from the table. Then it writes the status word and the preserved program counter onto a stack that grows toward lower addresses.

When the last write is acknowledged, the sequencer hands the core the new program counter with a one-cycle load strobe. In the same cycle it hands over the lowered stack pointer with its own load strobe. No delay slot follows, so the core fetches from the handler address next. Every memory access waits for an acknowledge, so slow memories simply stretch the sequence. The request fields are captured when the request is accepted, and later changes on those inputs have no effect.

Top module: `exc_entry_seq`

## Requirements
- R1: Each accepted request produces exactly three memory accesses, one at a time, in this order: table read, status write, PC write. The jump follows them, and no memory access is requested in the jump cycle.
- R2: The table read has mem_we=0 and address vec_base + 4*req_vec, both taken as captured at acceptance.
- R3: The status write has mem_we=1, address cur_sp-4 and data cur_sr, with 32-bit modular address arithmetic.
- R4: The PC write has mem_we=1, address cur_sp-8 and data req_pc.
- R5: pc_load is high for exactly one cycle. That cycle comes immediately after the cycle in which the PC write is acknowledged, and in it pc_out equals the word returned by the table read.
- R6: sp_load is high in exactly the cycles where pc_load is high, and then sp_out equals cur_sp-8.
- R7: req_ready is high only while idle. A request is accepted on a clock edge where req_valid and req_ready are both high. Requests and input changes while busy are ignored, and a request held pending is accepted once the jump has completed.
- R8: While mem_req is high and mem_ack is low, mem_req stays high and mem_addr, mem_we and mem_wdata hold their values into the next cycle.
- R9: While rst is high, or in the cycle after it falls, req_ready=1 and mem_req, pc_load and sp_load are 0. A reset during a sequence abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_vec | input | VEC_W | Exception number indexing the handler table |
| req_pc | input | XLEN | Program counter value to preserve |
| cur_sr | input | XLEN | Current status word |
| cur_sp | input | XLEN | Current stack pointer |
| vec_base | input | XLEN | Byte address of handler table entry 0 |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | XLEN | Byte address of the access |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid with mem_ack on a read |
| mem_ack | input | 1 | Access completes on this clock edge |
| pc_out | output | XLEN | Handler address for the core |
| pc_load | output | 1 | One-cycle strobe to load pc_out |
| sp_out | output | XLEN | Stack pointer after both pushes |
| sp_load | output | 1 | Strobe to load sp_out |

## Verification
A wrong phase register would show at once, in the cycle after the faulty edge. It would appear as an access with the wrong direction or address, as a fourth access, or as a jump strobe that does not follow the PC-write acknowledge by exactly one cycle. Wrongly captured request fields would show in the addresses or data of the next write, or in pc_out and sp_out at the jump. The bench drives acknowledge delays from zero to several cycles. This exposes any access that advances without its acknowledge, or that changes its address or data while it waits. Requests kept pending during a busy sequence check that the captured values are not overwritten.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_VEC  = 3'd1,
    PH_PSR  = 3'd2,
    PH_PPC  = 3'd3,
    PH_JMP  = 3'd4
  } phase_t;
endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_entry_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   mem_ack,
  output phase_t phase,
  output logic   idle,
  output logic   accept,
  output logic   access,
  output logic   write,
  output logic   jump
);
  phase_t nxt;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= nxt;
  end

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (req_valid) nxt = PH_VEC;
      PH_VEC:  if (mem_ack)   nxt = PH_PSR;
      PH_PSR:  if (mem_ack)   nxt = PH_PPC;
      PH_PPC:  if (mem_ack)   nxt = PH_JMP;
      PH_JMP:                 nxt = PH_IDLE;
      default:                nxt = PH_IDLE;
    endcase
  end

  assign idle   = (phase == PH_IDLE);
  assign accept = idle && req_valid;
  assign access = (phase == PH_VEC) || (phase == PH_PSR) || (phase == PH_PPC);
  assign write  = (phase == PH_PSR) || (phase == PH_PPC);
  assign jump   = (phase == PH_JMP);

  // R1
  jump_follows_pc_write_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PPC && mem_ack) |=> (phase == PH_JMP));
  // R7
  jump_returns_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_JMP) |=> (phase == PH_IDLE));
endmodule

// File: rtl/exc_addr_unit.sv
module exc_addr_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  phase_t           phase,
  input  logic             mem_ack,
  input  logic [VEC_W-1:0] req_vec,
  input  logic [XLEN-1:0]  req_pc,
  input  logic [XLEN-1:0]  cur_sr,
  input  logic [XLEN-1:0]  cur_sp,
  input  logic [XLEN-1:0]  vec_base,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic [XLEN-1:0]  pc_out,
  output logic [XLEN-1:0]  sp_out
);
  localparam int          WORD_B = 4;
  localparam logic [XLEN-1:0] STEP1 = XLEN'(WORD_B);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * WORD_B);

  logic [VEC_W-1:0] vec_q;
  logic [XLEN-1:0]  pc_q, sr_q, sp_q, base_q, hnd_q;
  logic [XLEN-1:0]  tbl_addr, sr_slot, pc_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      pc_q   <= '0;
      sr_q   <= '0;
      sp_q   <= '0;
      base_q <= '0;
      hnd_q  <= '0;
    end else begin
      if (accept) begin
        vec_q  <= req_vec;
        pc_q   <= req_pc;
        sr_q   <= cur_sr;
        sp_q   <= cur_sp;
        base_q <= vec_base;
      end
      if (phase == PH_VEC && mem_ack) hnd_q <= mem_rdata;
    end
  end

  assign tbl_addr = base_q + (XLEN'(vec_q) << 2);
  assign sr_slot  = sp_q - STEP1;
  assign pc_slot  = sp_q - STEP2;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (phase)
      PH_VEC: mem_addr = tbl_addr;
      PH_PSR: begin mem_addr = sr_slot; mem_wdata = sr_q; end
      PH_PPC: begin mem_addr = pc_slot; mem_wdata = pc_q; end
      default: ;
    endcase
  end

  assign pc_out = hnd_q;
  assign sp_out = pc_slot;

  // R3
  sr_slot_order_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PSR && mem_ack) |=> (mem_addr == $past(mem_addr) - STEP1));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VEC_W-1:0] req_vec,
  input  logic [XLEN-1:0]  req_pc,
  input  logic [XLEN-1:0]  cur_sr,
  input  logic [XLEN-1:0]  cur_sp,
  input  logic [XLEN-1:0]  vec_base,
  output logic             mem_req,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic             mem_ack,
  output logic [XLEN-1:0]  pc_out,
  output logic             pc_load,
  output logic [XLEN-1:0]  sp_out,
  output logic             sp_load
);
  phase_t phase;
  logic   idle, accept, access, write, jump;

  exc_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .mem_ack   (mem_ack),
    .phase     (phase),
    .idle      (idle),
    .accept    (accept),
    .access    (access),
    .write     (write),
    .jump      (jump)
  );

  exc_addr_unit #(.XLEN(XLEN), .VEC_W(VEC_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .phase     (phase),
    .mem_ack   (mem_ack),
    .req_vec   (req_vec),
    .req_pc    (req_pc),
    .cur_sr    (cur_sr),
    .cur_sp    (cur_sp),
    .vec_base  (vec_base),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_out    (pc_out),
    .sp_out    (sp_out)
  );

  assign req_ready = idle;
  assign mem_req   = access;
  assign mem_we    = write;
  assign pc_load   = jump;
  assign sp_load   = jump;

  // R1
  read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !mem_we) |=> (mem_req && mem_we));
  // R1
  no_access_in_jump_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_load, mem_req}));
  // R5
  pc_load_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> $past(mem_req && mem_we && mem_ack));
  // R5
  pc_load_single_chk: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !pc_load);
  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R8
  hold_while_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;
  localparam int XLEN = 32;
  localparam int VEC_W = 8;
  localparam int NV = 6;
  localparam logic [VEC_W-1:0] T_VEC [NV] = '{8'd0, 8'd5, 8'd255, 8'd12, 8'd64, 8'd1};
  localparam logic [31:0] T_PC   [NV] = '{32'h0000_1000, 32'h8000_0F02, 32'hFFFF_FFFE,
                                          32'h1234_5678, 32'h0000_0000, 32'hDEAD_BEEE};
  localparam logic [31:0] T_SR   [NV] = '{32'h0000_00F0, 32'h4000_0001, 32'hFFFF_FFFF,
                                          32'h0000_0000, 32'h7000_00A3, 32'h0000_0300};
  localparam logic [31:0] T_SP   [NV] = '{32'h0000_8000, 32'h2000_0100, 32'h0000_0004,
                                          32'hFFFF_FFF0, 32'h0001_0008, 32'h0000_0008};
  localparam logic [31:0] T_BASE [NV] = '{32'h0000_0000, 32'h0400_0000, 32'hFFFF_F000,
                                          32'h0000_0200, 32'h1000_0000, 32'hFFFF_FFFC};
  localparam int          T_DLY  [NV] = '{0, 1, 3, 2, 0, 4};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VEC_W-1:0] req_vec = '0;
  logic [31:0] req_pc = '0, cur_sr = '0, cur_sp = '0, vec_base = '0;
  logic mem_req, mem_we, pc_load, sp_load;
  logic [31:0] mem_addr, mem_wdata, pc_out, sp_out;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_seq #(.XLEN(XLEN), .VEC_W(VEC_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vec(req_vec), .req_pc(req_pc), .cur_sr(cur_sr), .cur_sp(cur_sp),
    .vec_base(vec_base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .pc_out(pc_out), .pc_load(pc_load), .sp_out(sp_out), .sp_load(sp_load)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, dly = 0, wcnt = 0;
  int lg_n = 0, ack_cyc = 0, jmp_n = 0, jmp_cyc = 0;
  int hold_err = 0, overlap_err = 0, sp_err = 0;
  logic [31:0] lg_addr [3];
  logic [31:0] lg_data [3];
  logic        lg_we   [3];
  logic [31:0] jmp_pc, jmp_sp, p_addr, p_data;
  logic        p_we;

  function automatic logic [31:0] tbl_word(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // memory responder and port monitor, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (pc_load) begin
        jmp_pc = pc_out;
        jmp_sp = sp_out;
        jmp_cyc = cyc;
        if (mem_req) overlap_err++;
        jmp_n++;
      end
      if (pc_load != sp_load) sp_err++;
      mem_ack = 1'b0;
      if (mem_req && !rst) begin
        if (wcnt > 0 && (mem_addr != p_addr || mem_wdata != p_data || mem_we != p_we))
          hold_err++;
        p_addr = mem_addr; p_data = mem_wdata; p_we = mem_we;
        if (wcnt >= dly) begin
          mem_ack = 1'b1;
          mem_rdata = tbl_word(mem_addr);
          if (lg_n < 3) begin
            lg_addr[lg_n] = mem_addr; lg_data[lg_n] = mem_wdata; lg_we[lg_n] = mem_we;
          end
          lg_n++;
          ack_cyc = cyc;
          wcnt = 0;
        end else wcnt++;
      end else wcnt = 0;
    end
  end

  task automatic check_seq(input logic [VEC_W-1:0] v, input logic [31:0] pc,
                           input logic [31:0] sr, input logic [31:0] sp,
                           input logic [31:0] base);
    logic [31:0] ta;
    ta = base + {22'd0, v, 2'b00};
    chk(lg_n == 3, "R1 access count", 32'(lg_n), 32'd3);
    chk(!lg_we[0] && lg_addr[0] == ta, "R2 table read addr", lg_addr[0], ta);
    chk(lg_we[1] && lg_addr[1] == sp - 32'd4, "R3 status addr", lg_addr[1], sp - 32'd4);
    chk(lg_data[1] == sr, "R3 status data", lg_data[1], sr);
    chk(lg_we[2] && lg_addr[2] == sp - 32'd8, "R4 pc addr", lg_addr[2], sp - 32'd8);
    chk(lg_data[2] == pc, "R4 pc data", lg_data[2], pc);
    chk(jmp_pc == tbl_word(ta), "R5 handler pc", jmp_pc, tbl_word(ta));
    chk(jmp_cyc == ack_cyc + 1, "R5 jump timing", 32'(jmp_cyc), 32'(ack_cyc + 1));
    chk(jmp_sp == sp - 32'd8, "R6 new sp", jmp_sp, sp - 32'd8);
    lg_n = 0;
  endtask

  task automatic drive(input logic [VEC_W-1:0] v, input logic [31:0] pc,
                       input logic [31:0] sr, input logic [31:0] sp,
                       input logic [31:0] base);
    req_vec = v; req_pc = pc; cur_sr = sr; cur_sp = sp; vec_base = base;
  endtask

  initial begin
    int target;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9 ready in reset", 32'(req_ready), 32'd1);
    chk(!mem_req && !pc_load && !sp_load, "R9 quiet in reset",
        {29'd0, mem_req, pc_load, sp_load}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req, "R9 idle after reset", {30'd0, req_ready, mem_req}, 32'd2);

    for (int i = 0; i < NV; i++) begin
      dly = T_DLY[i];
      lg_n = 0;
      target = jmp_n + 1;
      drive(T_VEC[i], T_PC[i], T_SR[i], T_SP[i], T_BASE[i]);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      // R7 changed inputs while busy have no effect
      drive(~T_VEC[i], 32'h0BAD_0BAD, 32'h5555_AAAA, 32'h0000_1234, 32'h7777_0000);
      chk(req_ready == 1'b0, "R7 busy not ready", 32'(req_ready), 32'd0);
      wait (jmp_n == target);
      check_seq(T_VEC[i], T_PC[i], T_SR[i], T_SP[i], T_BASE[i]);
      @(negedge clk);
    end

    // R7 request held pending during a busy sequence
    dly = 2;
    lg_n = 0;
    target = jmp_n + 1;
    drive(8'd9, 32'hA000_0010, 32'h0000_0011, 32'h0000_4000, 32'h0000_0100);
    req_valid = 1'b1;
    @(negedge clk);
    drive(8'd33, 32'hB000_0020, 32'h0000_0022, 32'h0000_6000, 32'h0000_0800);
    for (int k = 0; k < 4; k++) begin
      chk(req_ready == 1'b0, "R7 held off", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    wait (jmp_n == target);
    check_seq(8'd9, 32'hA000_0010, 32'h0000_0011, 32'h0000_4000, 32'h0000_0100);
    target = jmp_n + 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready after jump", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    wait (jmp_n == target);
    check_seq(8'd33, 32'hB000_0020, 32'h0000_0022, 32'h0000_6000, 32'h0000_0800);
    @(negedge clk);

    // R9 reset during a sequence abandons it
    dly = 5;
    target = jmp_n;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req, "R9 abandon", {30'd0, req_ready, mem_req}, 32'd2);
    repeat (8) @(negedge clk);
    chk(jmp_n == target, "R9 no jump after reset", 32'(jmp_n), 32'(target));

    chk(hold_err == 0, "R8 hold while waiting", 32'(hold_err), 32'd0);
    chk(overlap_err == 0, "R1 no access in jump", 32'(overlap_err), 32'd0);
    chk(sp_err == 0, "R6 sp_load with pc_load", 32'(sp_err), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule